// File: doc/BRIEF.md
# Tiled Single-Port RAM with Selectable Organisation

This block is a single-port synchronous RAM assembled from smaller behavioural memory tiles. One elaboration parameter selects how the tiles are arranged. In the depth-tiled arrangement, sixteen equal tiles each hold a contiguous slice of the address range at full data width. A one-hot select from the upper four address bits enables a single tile, and the same bits, registered, steer a 16-to-1 read multiplexer. In the bit-tiled arrangement, each tile is one bit wide and half the address range deep. The top address bit picks one of two banks, each bank holding one tile per data bit, and the registered top bit drives a 2-to-1 read multiplexer.

The block takes one access in every cycle in which `en` is high. It never stalls and has no back-pressure, so no valid/ready handshake is present: the caller owns the timing. Reads return data one cycle after the access. The `tiles_on` output reports how many tiles the current access enables. A testbench or power study can use it as an activity proxy to compare the two arrangements. With `ADDR_W = 15` the block holds 32K words. The default is set smaller so that elaboration stays light, and the tiling rules are the same at any depth.

Top module: `tiled_sram`

## Requirements
- R1: While `rst_n` is low and after its release, `rdata` is all zeros until the first read completes, and `tiles_on` is 0 whenever `en` is low.
- R2: A read (`en`=1, `we`=0) of address A at clock edge t presents the word most recently written to A on `rdata` after edge t, for back-to-back reads at any addresses.
- R3: With `ORG` = depth-tiled, every access enables exactly one tile, chosen by the upper 4 address bits, and `tiles_on` equals 1.
- R4: With `ORG` = bit-tiled, every access enables one whole bank of `DATA_W` one-bit tiles, chosen by address bit `ADDR_W-1`, and `tiles_on` equals `DATA_W`.
- R5: When `en` is low, no tile is enabled, no memory word changes even if `we` is high, and `rdata` holds its value.
- R6: A write cycle (`en`=1, `we`=1) leaves `rdata` unchanged after the edge.
- R7: A write to one address leaves every other address unchanged.
- R8: Both organisations return identical `rdata` for the same access sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| en | input | 1 | Access enable for this cycle |
| we | input | 1 | 1 = write, 0 = read, when `en` is high |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one cycle after a read |
| tiles_on | output | CNT_W | Number of tiles enabled in this cycle |

## Verification
The bench runs two copies, one per organisation, side by side under the same stimulus. It sweeps every address for writes and then reads, so each tile boundary and the bank boundary at the middle of the range is crossed. A decoder that hit the wrong tile, or a read multiplexer steered by the live address rather than the registered one, would return a neighbour's word or the previous word. Writes issued with `en` low, and a single overwrite followed by a full re-read, expose a design that leaks writes or lets `rdata` drift on write and idle cycles. The `tiles_on` value is checked on every driven cycle, so an enable decode that lights extra tiles would show up at once.

// File: rtl/tiled_sram_pkg.sv
package tiled_sram_pkg;
  typedef enum logic {
    ORG_DEPTH = 1'b0,  // full-width tiles, each a slice of the address range
    ORG_BIT   = 1'b1   // one-bit tiles, two banks split on the top address bit
  } org_e;
endpackage

// File: rtl/mem_tile.sv
module mem_tile #(
  parameter int W     = 1,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) store[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (en && !we)  rdata <= store[addr];
  end

  // R5: a tile that is not enabled keeps its output register
  assert_tile_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));
endmodule

// File: rtl/tile_select.sv
module tile_select #(
  parameter int SEL_W = 4,
  localparam int N    = 2 ** SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     tile_en
);
  always_comb begin
    tile_en = '0;
    for (int i = 0; i < N; i++) begin
      if (en && (sel == SEL_W'(i))) tile_en[i] = 1'b1;
    end
  end
endmodule

// File: rtl/out_mux.sv
module out_mux #(
  parameter int W     = 16,
  parameter int SEL_W = 4,
  localparam int N    = 2 ** SEL_W
) (
  input  logic [N-1:0][W-1:0] din,
  input  logic [SEL_W-1:0]    sel,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) dout = din[i];
    end
  end
endmodule

// File: rtl/tiled_sram.sv
module tiled_sram
  import tiled_sram_pkg::*;
#(
  parameter org_e ORG        = ORG_DEPTH,
  parameter int   DATA_W     = 16,
  parameter int   ADDR_W     = 8,
  parameter int   TILE_SEL_W = 4,
  localparam int  CNT_W      = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  tiles_on
);
  logic rd_acc;
  assign rd_acc = en && !we;

  if (ORG == ORG_DEPTH) begin : g_depth
    localparam int SEL_W  = TILE_SEL_W;
    localparam int N      = 2 ** SEL_W;
    localparam int LOW_W  = ADDR_W - SEL_W;
    localparam int TDEPTH = 2 ** LOW_W;

    logic [N-1:0]             tile_en;
    logic [N-1:0][DATA_W-1:0] tile_q;
    logic [SEL_W-1:0]         sel_q;

    tile_select #(.SEL_W(SEL_W)) u_dec (
      .en(en), .sel(addr[ADDR_W-1 -: SEL_W]), .tile_en(tile_en));

    for (genvar t = 0; t < N; t++) begin : g_tile
      mem_tile #(.W(DATA_W), .DEPTH(TDEPTH)) u_tile (
        .clk(clk), .rst_n(rst_n), .en(tile_en[t]), .we(we),
        .addr(addr[LOW_W-1:0]), .wdata(wdata), .rdata(tile_q[t]));
    end

    // Select follows the read that produced the tile data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (rd_acc) sel_q <= addr[ADDR_W-1 -: SEL_W];
    end

    out_mux #(.W(DATA_W), .SEL_W(SEL_W)) u_mux (
      .din(tile_q), .sel(sel_q), .dout(rdata));

    assign tiles_on = CNT_W'($countones(tile_en));

    // R3: one tile per access, none when idle
    assert_single_tile_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ($countones(tile_en) == 1));
    assert_no_tile_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (tile_en == '0));
  end else begin : g_bit
    localparam int LOW_W  = ADDR_W - 1;
    localparam int TDEPTH = 2 ** LOW_W;

    logic [1:0]               bank_en;
    logic [1:0][DATA_W-1:0]   bank_q;
    logic                     sel_q;
    logic [2*DATA_W-1:0]      all_en;

    tile_select #(.SEL_W(1)) u_dec (
      .en(en), .sel(addr[ADDR_W-1]), .tile_en(bank_en));

    for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar d = 0; d < DATA_W; d++) begin : g_lane
        mem_tile #(.W(1), .DEPTH(TDEPTH)) u_tile (
          .clk(clk), .rst_n(rst_n), .en(bank_en[b]), .we(we),
          .addr(addr[LOW_W-1:0]), .wdata(wdata[d]), .rdata(bank_q[b][d]));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= 1'b0;
      else if (rd_acc) sel_q <= addr[ADDR_W-1];
    end

    out_mux #(.W(DATA_W), .SEL_W(1)) u_mux (
      .din(bank_q), .sel(sel_q), .dout(rdata));

    assign all_en   = {{DATA_W{bank_en[1]}}, {DATA_W{bank_en[0]}}};
    assign tiles_on = CNT_W'($countones(all_en));

    // R4: one whole bank per access, never both
    assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ($countones(bank_en) == 1));
    assert_bank_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (tiles_on == CNT_W'(DATA_W)));
  end

  // R5 and R6: read data moves only after a read
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || we) |=> $stable(rdata));
  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (tiles_on == '0));
endmodule

// File: tb/tiled_sram_tb.sv
module tiled_sram_tb;
  import tiled_sram_pkg::*;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = $clog2(2 * DW + 1);
  localparam int NW = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_d, rd_b;
  logic [CW-1:0] on_d, on_b;
  logic [DW-1:0] model [NW];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tiled_sram #(.ORG(ORG_DEPTH), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rd_d), .tiles_on(on_d));

  tiled_sram #(.ORG(ORG_BIT), .DATA_W(DW), .ADDR_W(AW)) u_dut_bit (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rd_b), .tiles_on(on_b));

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 40503 + salt * 977) ^ 16'h3C5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle and returns at the next negedge
  task automatic acc(input logic e, input logic w, input int a, input logic [DW-1:0] d);
    en = e; we = w; addr = AW'(a); wdata = d;
    #1;
    chk(e ? "R3 depth tiles_on" : "R5 depth idle", 32'(on_d), e ? 32'd1 : 32'd0);
    chk(e ? "R4 bit tiles_on" : "R5 bit idle", 32'(on_b), e ? 32'(DW) : 32'd0);
    @(negedge clk);
  endtask

  task automatic rd_check(input string req, input int a);
    acc(1'b1, 1'b0, a, '0);
    chk(req, 32'(rd_d), 32'(model[a]));
    chk("R8 modes agree", 32'(rd_b), 32'(rd_d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata depth", 32'(rd_d), 32'd0);
    chk("R1 reset rdata bit", 32'(rd_b), 32'd0);
    chk("R1 reset tiles_on", 32'(on_d) + 32'(on_b), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(rd_d) | 32'(rd_b), 32'd0);

    // Fill every word; rdata must not move on writes
    for (int a = 0; a < NW; a++) begin
      model[a] = pat(a, 0);
      prev = rd_d;
      acc(1'b1, 1'b1, a, model[a]);
      chk("R6 write hold", 32'(rd_d), 32'(prev));
    end

    // Full read sweep crossing every tile and the bank boundary
    for (int a = 0; a < NW; a++) rd_check("R2 sweep read", a);

    // Writes with en low must leave memory and rdata alone
    rd_check("R2 before idle", 5);
    for (int a = 0; a < NW; a += 17) begin
      prev = rd_d;
      acc(1'b0, 1'b1, a, ~model[a]);
      chk("R5 idle rdata hold", 32'(rd_d), 32'(prev));
      chk("R5 idle rdata hold bit", 32'(rd_b), 32'(prev));
    end
    for (int a = 0; a < NW; a += 17) rd_check("R5 no idle write", a);

    // Single overwrite, then confirm all other words unchanged
    model[8'h37] = ~model[8'h37];
    acc(1'b1, 1'b1, 8'h37, model[8'h37]);
    for (int a = 0; a < NW; a++) rd_check("R7 isolation", a);

    // Back-to-back reads and writes at tile and bank edges
    for (int k = 0; k < 8; k++) begin
      int a;
      a = (k == 0) ? 0 : (k == 1) ? 15 : (k == 2) ? 16 : (k == 3) ? 127 :
          (k == 4) ? 128 : (k == 5) ? 129 : (k == 6) ? 240 : 255;
      model[a] = pat(a, k + 1);
      prev = rd_d;
      acc(1'b1, 1'b1, a, model[a]);
      chk("R6 edge write hold", 32'(rd_d), 32'(prev));
      rd_check("R2 edge read", a);
      rd_check("R2 edge mirror", NW - 1 - a);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule